// File: doc/BRIEF.md
# Timeslot PRBS Test Engine

This block inserts a 2^15-1 pseudo-random test pattern into one direction of a framed serial TDM stream and checks for the same pattern arriving on the other direction. An external framer supplies, with every bit strobe, the timeslot number and the bit position inside that timeslot. The block does no framing of its own. A direction input picks the path that carries the generated pattern. The checker always looks at the incoming data of the opposite path.

A two-bit mode field chooses one of three schemes. In unframed operation every bit of the stream is used. In 8-bit timeslot operation only the timeslots enabled in a 32-entry bitmap are used. 7-bit timeslot operation is the same, but the last bit of each enabled timeslot is skipped. The fourth mode code turns the engine off. Unused bits pass through unchanged. The generator and the checker register advance only on used bits.

The checker is self-synchronizing: it predicts each bit from the last fifteen bits it received. It declares sync after a run of correct predictions and drops sync when too many errors fall inside a block of bits. While in sync it counts mismatches in a saturating counter that is cleared by a read strobe.

Top module: `tsprbs_engine`

## Requirements
- R1: With cfg_dir=0 the pattern replaces used bits on tx_out and the checker observes rx_in. With cfg_dir=1 the pattern replaces used bits on rx_out and the checker observes tx_in. The output that does not carry the pattern always equals its input.
- R2: cfg_mode codes are 00 unframed, 01 8-bit timeslot, 10 7-bit timeslot and 11 off. With 11 both outputs equal their inputs, the generator does not advance and the checker ignores all bits.
- R3: In unframed mode every strobed bit (bit_valid=1) is used, whatever cfg_ts_en holds.
- R4: In both timeslot modes a strobed bit is used only when cfg_ts_en bit n is 1, where n is ts_idx.
- R5: In 7-bit mode a bit with bit_idx=7 is never used, even in an enabled timeslot. It passes through unchanged and is not checked. bit_idx 0 is the first bit of a timeslot and bit_idx 7 is the last.
- R6: The generator is a 15-bit shift register seeded to all ones at reset. Each used bit emits s[14] XOR s[13] and shifts that bit in at position 0. The register does not change on unused bits.
- R7: On each used bit the checker compares the incoming bit with s[14] XOR s[13] of its own register, then shifts the incoming bit in. A single flipped bit therefore gives three mismatches, and the register reseeds itself from the incoming data.
- R8: Out of sync, chk_sync rises after 32 consecutive matching used bits. The run restarts at zero on any mismatch.
- R9: In sync, used bits are grouped into 64-bit blocks counted from the bit after sync was gained. A sixth mismatch within one block drops chk_sync after that bit, and acquisition starts again.
- R10: err_cnt increments on each mismatch seen while chk_sync is 1 and saturates at its all-ones value. Mismatches seen out of sync are not counted.
- R11: An err_rd pulse clears err_cnt on the next clock edge. A mismatch counted in the same cycle leaves err_cnt at 1.
- R12: After reset chk_sync=0 and err_cnt=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_dir | input | 1 | 0: generate on transmit, check receive; 1: the reverse |
| cfg_mode | input | 2 | Operating mode code |
| cfg_ts_en | input | 32 | Per-timeslot test enable bitmap |
| bit_valid | input | 1 | Strobe, one per serial bit |
| ts_idx | input | 5 | Timeslot number of the current bit |
| bit_idx | input | 3 | Bit position inside the timeslot, 0 first |
| tx_in | input | 1 | Transmit-path data in |
| rx_in | input | 1 | Receive-path data in |
| tx_out | output | 1 | Transmit-path data out |
| rx_out | output | 1 | Receive-path data out |
| chk_sync | output | 1 | Checker in pattern sync |
| err_cnt | output | ERR_W | Saturating mismatch count |
| err_rd | input | 1 | Read strobe that clears err_cnt |

## Verification
A table walks every mode in both directions with timeslot and bit positions that are enabled, disabled and last-in-slot. It compares each output bit with a reference sequence that moves only on used bits, so a wrong use decision also shows up as a shifted pattern later on. A looped-back stream then tests acquisition at exactly 32 bits, and single-bit flips placed one per block separate the three-error signature, counting, saturation and clearing. Two flips in one block give the sixth error on a known bit, which tests the loss of sync. A flip while out of sync tests that nothing is counted, followed by reacquisition.

// File: rtl/tsprbs_pkg.sv
package tsprbs_pkg;
    typedef enum logic [1:0] {
        MODE_UNFRAMED = 2'b00,
        MODE_TS8      = 2'b01,
        MODE_TS7      = 2'b10,
        MODE_OFF      = 2'b11
    } tsprbs_mode_e;
endpackage

// File: rtl/tsprbs_slot_sel.sv
module tsprbs_slot_sel
    import tsprbs_pkg::*;
#(
    parameter int TS_NUM = 32,
    parameter int BIT_W  = 3,
    localparam int TS_W  = $clog2(TS_NUM),
    localparam int LAST_BIT = (1 << BIT_W) - 1
) (
    input  logic [1:0]        mode,
    input  logic [TS_NUM-1:0] ts_en,
    input  logic              bit_valid,
    input  logic [TS_W-1:0]   ts_idx,
    input  logic [BIT_W-1:0]  bit_idx,
    output logic              bit_use
);
    logic slot_on;
    logic last_bit;

    always_comb begin
        slot_on  = ts_en[ts_idx];
        last_bit = (bit_idx == BIT_W'(LAST_BIT));
        unique case (tsprbs_mode_e'(mode))
            MODE_UNFRAMED: bit_use = bit_valid;
            MODE_TS8:      bit_use = bit_valid & slot_on;
            MODE_TS7:      bit_use = bit_valid & slot_on & ~last_bit;
            default:       bit_use = 1'b0;
        endcase
    end
endmodule

// File: rtl/tsprbs_gen.sv
module tsprbs_gen #(
    parameter int LFSR_W = 15,
    parameter int TAP_A  = 14,
    parameter int TAP_B  = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic pat_bit
);
    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
    } gen_st_t;

    gen_st_t st_d, st_q;

    always_comb begin
        pat_bit = st_q.lfsr[TAP_A] ^ st_q.lfsr[TAP_B];
        st_d    = st_q;
        if (adv) begin
            st_d.lfsr = {st_q.lfsr[LFSR_W-2:0], pat_bit};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lfsr <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) st_q.lfsr != '0); // R6
    AST_GEN_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !adv |=> $stable(st_q.lfsr)); // R6
endmodule

// File: rtl/tsprbs_checker.sv
module tsprbs_checker #(
    parameter int LFSR_W    = 15,
    parameter int TAP_A     = 14,
    parameter int TAP_B     = 13,
    parameter int SYNC_RUN  = 32,
    parameter int BLK_LEN   = 64,
    parameter int LOSS_ERRS = 6,
    parameter int ERR_W     = 16,
    localparam int RUN_W    = $clog2(SYNC_RUN),
    localparam int BLK_W    = $clog2(BLK_LEN),
    localparam int BE_W     = $clog2(LOSS_ERRS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             use_bit,
    input  logic             din,
    input  logic             rd,
    output logic             sync,
    output logic [ERR_W-1:0] err_cnt
);
    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    typedef struct packed {
        logic [LFSR_W-1:0] sr;
        logic [RUN_W-1:0]  run;
        logic              sync;
        logic [BLK_W-1:0]  blk;
        logic [BE_W-1:0]   berr;
        logic [ERR_W-1:0]  err;
    } chk_st_t;

    chk_st_t st_d, st_q;
    logic    pred;
    logic    mis;
    logic [BE_W-1:0] berr_n;

    always_comb begin
        st_d   = st_q;
        pred   = st_q.sr[TAP_A] ^ st_q.sr[TAP_B];
        mis    = use_bit & (din ^ pred);
        berr_n = st_q.berr + BE_W'(mis);
        if (rd) begin
            st_d.err = '0;
        end
        if (use_bit) begin
            st_d.sr = {st_q.sr[LFSR_W-2:0], din};
            if (!st_q.sync) begin
                if (mis) begin
                    st_d.run = '0;
                end else if (st_q.run == RUN_W'(SYNC_RUN - 1)) begin
                    st_d.sync = 1'b1;
                    st_d.run  = '0;
                    st_d.blk  = '0;
                    st_d.berr = '0;
                end else begin
                    st_d.run = st_q.run + 1'b1;
                end
            end else begin
                if (mis) begin
                    if (rd) begin
                        st_d.err = ERR_W'(1);
                    end else if (st_q.err != ERR_MAX) begin
                        st_d.err = st_q.err + 1'b1;
                    end
                end
                if (berr_n == BE_W'(LOSS_ERRS)) begin
                    st_d.sync = 1'b0;
                    st_d.run  = '0;
                    st_d.blk  = '0;
                    st_d.berr = '0;
                end else if (st_q.blk == BLK_W'(BLK_LEN - 1)) begin
                    st_d.blk  = '0;
                    st_d.berr = '0;
                end else begin
                    st_d.blk  = st_q.blk + 1'b1;
                    st_d.berr = berr_n;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sr   <= '1;
            st_q.run  <= '0;
            st_q.sync <= 1'b0;
            st_q.blk  <= '0;
            st_q.berr <= '0;
            st_q.err  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync    = st_q.sync;
    assign err_cnt = st_q.err;

    AST_SYNC_ONLY_ON_USE: assert property (@(posedge clk) disable iff (!rst_n) !use_bit |=> $stable(sync)); // R8
    AST_BLOCK_ERR_BOUND: assert property (@(posedge clk) disable iff (!rst_n) st_q.berr < BE_W'(LOSS_ERRS)); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sync && use_bit && mis && !rd && err_cnt == ERR_MAX) |=> err_cnt == ERR_MAX); // R10
    AST_NO_COUNT_UNSYNC: assert property (@(posedge clk) disable iff (!rst_n) (!sync && !rd) |=> $stable(err_cnt)); // R10
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (rd && !(sync && mis)) |=> err_cnt == '0); // R11
endmodule

// File: rtl/tsprbs_engine.sv
module tsprbs_engine
    import tsprbs_pkg::*;
#(
    parameter int TS_NUM    = 32,
    parameter int BIT_W     = 3,
    parameter int LFSR_W    = 15,
    parameter int TAP_A     = 14,
    parameter int TAP_B     = 13,
    parameter int SYNC_RUN  = 32,
    parameter int BLK_LEN   = 64,
    parameter int LOSS_ERRS = 6,
    parameter int ERR_W     = 16,
    localparam int TS_W     = $clog2(TS_NUM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_dir,
    input  logic [1:0]        cfg_mode,
    input  logic [TS_NUM-1:0] cfg_ts_en,
    input  logic              bit_valid,
    input  logic [TS_W-1:0]   ts_idx,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic              tx_in,
    input  logic              rx_in,
    output logic              tx_out,
    output logic              rx_out,
    output logic              chk_sync,
    output logic [ERR_W-1:0]  err_cnt,
    input  logic              err_rd
);
    logic bit_use;
    logic pat_bit;
    logic chk_din;

    tsprbs_slot_sel #(.TS_NUM(TS_NUM), .BIT_W(BIT_W)) u_sel (
        .mode      (cfg_mode),
        .ts_en     (cfg_ts_en),
        .bit_valid (bit_valid),
        .ts_idx    (ts_idx),
        .bit_idx   (bit_idx),
        .bit_use   (bit_use)
    );

    tsprbs_gen #(.LFSR_W(LFSR_W), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (bit_use),
        .pat_bit (pat_bit)
    );

    always_comb begin
        tx_out  = (!cfg_dir && bit_use) ? pat_bit : tx_in;
        rx_out  = ( cfg_dir && bit_use) ? pat_bit : rx_in;
        chk_din = cfg_dir ? tx_in : rx_in;
    end

    tsprbs_checker #(
        .LFSR_W(LFSR_W), .TAP_A(TAP_A), .TAP_B(TAP_B), .SYNC_RUN(SYNC_RUN),
        .BLK_LEN(BLK_LEN), .LOSS_ERRS(LOSS_ERRS), .ERR_W(ERR_W)
    ) u_chk (
        .clk     (clk),
        .rst_n   (rst_n),
        .use_bit (bit_use),
        .din     (chk_din),
        .rd      (err_rd),
        .sync    (chk_sync),
        .err_cnt (err_cnt)
    );

    AST_OFF_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mode == MODE_OFF |-> (tx_out == tx_in && rx_out == rx_in)); // R2
    AST_TS7_LAST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == MODE_TS7 && bit_idx == '1) |-> (tx_out == tx_in && rx_out == rx_in)); // R5
    AST_DIR_IDLE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_dir ? (tx_out == tx_in) : (rx_out == rx_in)); // R1
endmodule

// File: tb/tsprbs_engine_tb_top.sv
module tsprbs_engine_tb_top;
    localparam int EW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_dir = 1'b0;
    logic [1:0] cfg_mode = 2'b00;
    logic [31:0] cfg_ts_en = 32'h0000_0009;
    logic bit_valid = 1'b0;
    logic [4:0] ts_idx = '0;
    logic [2:0] bit_idx = '0;
    logic tx_in = 1'b0;
    logic rx_drv = 1'b0;
    logic rx_in;
    logic tx_out, rx_out, chk_sync;
    logic [EW-1:0] err_cnt;
    logic err_rd = 1'b0;
    logic loop_en = 1'b0;
    logic flip = 1'b0;
    logic [14:0] gm = 15'h7FFF;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign rx_in = loop_en ? (tx_out ^ flip) : rx_drv;

    tsprbs_engine #(.ERR_W(EW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_dir(cfg_dir), .cfg_mode(cfg_mode),
        .cfg_ts_en(cfg_ts_en), .bit_valid(bit_valid), .ts_idx(ts_idx),
        .bit_idx(bit_idx), .tx_in(tx_in), .rx_in(rx_in), .tx_out(tx_out),
        .rx_out(rx_out), .chk_sync(chk_sync), .err_cnt(err_cnt), .err_rd(err_rd)
    );

    // {mode[1:0], dir, ts[4:0], bit[2:0], tx, rx}; bitmap enables timeslots 0 and 3
    localparam logic [12:0] VEC [15] = '{
        {2'd0, 1'b0, 5'd5,  3'd2, 1'b1, 1'b0},
        {2'd0, 1'b1, 5'd1,  3'd7, 1'b0, 1'b1},
        {2'd1, 1'b0, 5'd3,  3'd0, 1'b1, 1'b1},
        {2'd1, 1'b0, 5'd3,  3'd7, 1'b0, 1'b0},
        {2'd1, 1'b0, 5'd4,  3'd0, 1'b1, 1'b0},
        {2'd1, 1'b1, 5'd0,  3'd4, 1'b0, 1'b1},
        {2'd2, 1'b0, 5'd3,  3'd6, 1'b1, 1'b1},
        {2'd2, 1'b0, 5'd3,  3'd7, 1'b1, 1'b0},
        {2'd2, 1'b1, 5'd0,  3'd7, 1'b0, 1'b1},
        {2'd2, 1'b1, 5'd0,  3'd1, 1'b1, 1'b0},
        {2'd3, 1'b0, 5'd3,  3'd0, 1'b0, 1'b1},
        {2'd3, 1'b1, 5'd0,  3'd2, 1'b1, 1'b0},
        {2'd1, 1'b0, 5'd31, 3'd3, 1'b1, 1'b1},
        {2'd0, 1'b0, 5'd0,  3'd0, 1'b0, 1'b0},
        {2'd2, 1'b0, 5'd0,  3'd3, 1'b0, 1'b1}
    };

    function automatic logic used_f(logic [1:0] m, logic [31:0] en, logic [4:0] t, logic [2:0] b);
        case (m)
            2'b00:   return 1'b1;
            2'b01:   return en[t];
            2'b10:   return en[t] && (b != 3'd7);
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bit_valid = 1'b0;
        err_rd = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        gm = 15'h7FFF;
    endtask

    // one strobed bit; when docheck, both outputs are compared with the reference
    task automatic send(input logic [4:0] t, input logic [2:0] b, input logic txv,
                        input logic rxv, input logic fl, input bit docheck, input string req);
        logic u, pb, etx, erx;
        @(negedge clk);
        ts_idx = t; bit_idx = b; tx_in = txv; rx_drv = rxv; flip = fl;
        bit_valid = 1'b1;
        #2;
        u   = used_f(cfg_mode, cfg_ts_en, t, b);
        pb  = gm[14] ^ gm[13];
        etx = (!cfg_dir && u) ? pb : txv;
        erx = ( cfg_dir && u) ? pb : rxv;
        if (docheck) begin
            check(tx_out === etx, req, "tx_out", int'(tx_out), int'(etx));
            check(rx_out === erx, req, "rx_out", int'(rx_out), int'(erx));
        end
        @(posedge clk);
        if (u) gm = {gm[13:0], pb};
        #1;
        bit_valid = 1'b0;
        flip = 1'b0;
    endtask

    task automatic stream(input int n, input int f1, input int f2);
        for (int i = 0; i < n; i++) begin
            send(5'(i % 32), 3'(i % 8), 1'b0, 1'b0, (i == f1) || (i == f2), 1'b0, "");
        end
    endtask

    task automatic read_clear();
        @(negedge clk);
        bit_valid = 1'b0;
        err_rd = 1'b1;
        @(posedge clk);
        #1;
        err_rd = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        do_reset();
        #2;
        // R12 reset state
        check(chk_sync === 1'b0, "R12", "chk_sync after reset", int'(chk_sync), 0);
        check(err_cnt === '0, "R12", "err_cnt after reset", int'(err_cnt), 0);

        // R1 R2 R3 R4 R5 R6: mode and direction table
        for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            cfg_mode = VEC[k][12:11];
            cfg_dir  = VEC[k][10];
            send(VEC[k][9:5], VEC[k][4:2], VEC[k][1], VEC[k][0], 1'b0, 1'b1, "R1/R2/R3/R4/R5/R6");
        end

        // R6 pattern over a longer unframed run, generator on tx
        cfg_mode = 2'b00; cfg_dir = 1'b0;
        for (int i = 0; i < 20; i++) send(5'(i), 3'(i), 1'b1, 1'b0, 1'b0, 1'b1, "R6");

        // R2 off mode: generator must not advance across these bits
        cfg_mode = 2'b11;
        for (int i = 0; i < 5; i++) send(5'd0, 3'(i), 1'b1, 1'b1, 1'b0, 1'b1, "R2");
        cfg_mode = 2'b00;
        send(5'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R2");

        // checker tests in loopback
        do_reset();
        cfg_mode = 2'b00; cfg_dir = 1'b0; loop_en = 1'b1;
        stream(31, -1, -1);
        check(chk_sync === 1'b0, "R8", "sync after 31 bits", int'(chk_sync), 0);
        stream(1, -1, -1);
        check(chk_sync === 1'b1, "R8", "sync after 32 bits", int'(chk_sync), 1);

        stream(64, 5, -1);
        check(err_cnt === EW'(3), "R7", "errors from one flipped bit", int'(err_cnt), 3);
        check(chk_sync === 1'b1, "R9", "sync held at 3 errors per block", int'(chk_sync), 1);

        read_clear();
        check(err_cnt === '0, "R11", "err_cnt after read", int'(err_cnt), 0);

        for (int blk = 0; blk < 5; blk++) stream(64, 5, -1);
        check(err_cnt === EW'(15), "R10", "count after five blocks", int'(err_cnt), 15);
        stream(64, 5, -1);
        check(err_cnt === EW'(15), "R10", "saturated count", int'(err_cnt), 15);
        check(chk_sync === 1'b1, "R10", "sync during saturation", int'(chk_sync), 1);

        stream(35, 2, 20);
        check(chk_sync === 1'b1, "R9", "sync after fifth error", int'(chk_sync), 1);
        stream(1, -1, -1);
        check(chk_sync === 1'b0, "R9", "sync after sixth error", int'(chk_sync), 0);

        read_clear();
        stream(16, 0, -1);
        check(err_cnt === '0, "R10", "no count out of sync", int'(err_cnt), 0);
        check(chk_sync === 1'b0, "R8", "no sync with a recent mismatch", int'(chk_sync), 0);
        stream(31, -1, -1);
        check(chk_sync === 1'b0, "R9", "reacquire after 31", int'(chk_sync), 0);
        stream(1, -1, -1);
        check(chk_sync === 1'b1, "R9", "reacquire after 32", int'(chk_sync), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule